// File: doc/BRIEF.md
# Next-Fetch Address Predictor

This block chooses the address that an in-order core fetches next. The front end has two stages: in the fetch stage the block issues an address, and one cycle later, in the decode stage, the instruction at that address is presented back as a conditional-branch flag and a signed displacement. Each address is chosen in one of three ways. A one-entry branch target buffer is compared against the current fetch address. At decode, a fixed direction rule treats a conditional branch as taken when its displacement points backward. Resolution reports from the integer execute pipeline correct any wrong guess.

The fetch address leaves the block on a valid/ready handshake. While `fetch_ready` is low the address is held and no new instruction enters decode, so the stalled cycle leaves a bubble. Decode output, redirect and flush are plain signals with no back-pressure. The consumer of the decode output takes one instruction in every cycle in which `dx_valid` is high. A wrong prediction found at resolution has the highest priority. A backward-branch redirect from decode comes next, then a buffer hit, then the sequential address.

Top module: `nfp_next_fetch`

## Requirements
- R1: While reset is asserted, `fetch_pc` equals the RESET_PC parameter, and `fetch_valid`, `dx_valid` and `redir_valid` are 0. The buffer entry is invalid after reset.
- R2: A handshake (`fetch_valid` and `fetch_ready` both 1) with no buffer hit and no redirect advances `fetch_pc` by ILEN bytes, and that instruction appears at decode on the next cycle.
- R3: When `fetch_ready` is 0 and there is no redirect, `fetch_pc` holds its value and `dx_valid` is 0 on the next cycle.
- R4: When the entry is valid and its stored PC equals `fetch_pc`, a handshake makes the next `fetch_pc` equal the stored target. That instruction then shows `dx_pred_taken`=1 and `dx_pred_target` equal to the stored target.
- R5: A decoded conditional branch with displacement sign bit 1 that missed the buffer drives `redir_valid`=1 and `redir_pc`=PC+sign-extended displacement, and reports `dx_pred_taken`=1 with that target. The next `fetch_pc` is `redir_pc`, and the instruction fetched in the same cycle is squashed (`dx_valid`=0 on the next cycle).
- R6: A decoded instruction that is not a backward conditional branch and missed the buffer reports `dx_pred_taken`=0 and `dx_pred_target`=PC+ILEN, and causes no redirect.
- R7: A resolution report with `res_taken`=1 overwrites the single entry with `res_pc` and `res_target`. The new entry is effective from the next cycle.
- R8: A misprediction occurs when a resolution report has `res_taken`≠`res_pred_taken`, or has both set with `res_target`≠`res_pred_target`. It raises `flush` and `redir_valid`, and sets `redir_pc` to `res_target` if taken, otherwise `res_pc`+ILEN. It suppresses `dx_valid` in that cycle. The next `fetch_pc` is `redir_pc`, and decode is empty on the next cycle.
- R9: When a misprediction and a decode redirect occur in the same cycle, the misprediction's address wins.
- R10: A resolution report that matches its prediction raises no `flush`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | output | 1 | Fetch address valid |
| fetch_ready | input | 1 | Instruction memory accepts the fetch address |
| fetch_pc | output | XLEN | Current fetch address |
| dec_is_cond | input | 1 | Instruction in decode is a conditional branch |
| dec_disp | input | DISP_W | Signed displacement of the instruction in decode |
| dx_valid | output | 1 | Decode-stage instruction passes to execute |
| dx_pc | output | XLEN | PC of the decode-stage instruction |
| dx_pred_taken | output | 1 | Predicted direction |
| dx_pred_target | output | XLEN | Predicted next PC |
| res_valid | input | 1 | Branch resolution report valid |
| res_pc | input | XLEN | PC of the resolved branch |
| res_taken | input | 1 | Actual direction |
| res_target | input | XLEN | Actual taken target |
| res_pred_taken | input | 1 | Direction that was predicted |
| res_pred_target | input | XLEN | Target that was predicted |
| redir_valid | output | 1 | Fetch is being redirected |
| redir_pc | output | XLEN | Redirect address |
| flush | output | 1 | Squash all younger front-end instructions |

## Verification
The bench builds the block with XLEN 32, DISP_W 12, ILEN 4 and RESET_PC 0x100. The 12-bit displacement keeps both extremes of the field, -2048 and +2047, within random reach, so the sign test at decode is exercised at its boundary as well as in between. Random resolution reports reuse addresses the fetch stream has just visited, so buffer hits, overwrites and same-cycle priority conflicts all occur often.

// File: rtl/nfp_pkg.sv
package nfp_pkg;
  // Source of the next fetch address, in priority order (highest last)
  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_BTB = 2'd1,
    SRC_DEC = 2'd2,
    SRC_RES = 2'd3
  } nxt_src_e;
endpackage

// File: rtl/nfp_btb.sv
module nfp_btb #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] lk_pc,
  output logic            lk_hit,
  output logic [XLEN-1:0] lk_target,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_pc,
  input  logic [XLEN-1:0] wr_target
);
  logic            ent_valid;
  logic [XLEN-1:0] ent_pc;
  logic [XLEN-1:0] ent_target;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid  <= 1'b0;
      ent_pc     <= '0;
      ent_target <= '0;
    end else if (wr_en) begin
      ent_valid  <= 1'b1;
      ent_pc     <= wr_pc;
      ent_target <= wr_target;
    end
  end

  assign lk_hit    = ent_valid && (ent_pc == lk_pc);
  assign lk_target = ent_target;

  // R7
  btb_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (lk_pc != $past(wr_pc)) || (lk_hit && lk_target == $past(wr_target)));
endmodule

// File: rtl/nfp_static_dir.sv
module nfp_static_dir #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned DISP_W = 12,
  parameter int unsigned ILEN   = 4
) (
  input  logic              d_valid,
  input  logic [XLEN-1:0]   d_pc,
  input  logic              d_is_cond,
  input  logic [DISP_W-1:0] d_disp,
  input  logic              d_btb_hit,
  input  logic [XLEN-1:0]   d_btb_target,
  output logic              st_redirect,
  output logic [XLEN-1:0]   st_target,
  output logic              pred_taken,
  output logic [XLEN-1:0]   pred_target
);
  logic [XLEN-1:0] disp_ext;

  generate
    if (DISP_W < XLEN) begin : g_ext
      assign disp_ext = {{(XLEN-DISP_W){d_disp[DISP_W-1]}}, d_disp};
    end else begin : g_trunc
      assign disp_ext = d_disp[XLEN-1:0];
    end
  endgenerate

  logic backward;
  assign backward    = d_disp[DISP_W-1];
  assign st_target   = d_pc + disp_ext;
  assign st_redirect = d_valid && d_is_cond && backward && !d_btb_hit;
  assign pred_taken  = d_btb_hit || (d_is_cond && backward);

  always_comb begin
    if (d_btb_hit)               pred_target = d_btb_target;
    else if (d_is_cond && backward) pred_target = st_target;
    else                         pred_target = d_pc + XLEN'(ILEN);
  end
endmodule

// File: rtl/nfp_resolve.sv
module nfp_resolve #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned ILEN = 4
) (
  input  logic            res_valid,
  input  logic [XLEN-1:0] res_pc,
  input  logic            res_taken,
  input  logic [XLEN-1:0] res_target,
  input  logic            res_pred_taken,
  input  logic [XLEN-1:0] res_pred_target,
  output logic            mispredict,
  output logic [XLEN-1:0] fix_pc,
  output logic            upd_en
);
  logic dir_wrong, tgt_wrong;
  assign dir_wrong  = res_taken != res_pred_taken;
  assign tgt_wrong  = res_taken && res_pred_taken && (res_target != res_pred_target);
  assign mispredict = res_valid && (dir_wrong || tgt_wrong);
  assign fix_pc     = res_taken ? res_target : res_pc + XLEN'(ILEN);
  assign upd_en     = res_valid && res_taken;
endmodule

// File: rtl/nfp_next_fetch.sv
module nfp_next_fetch
  import nfp_pkg::*;
#(
  parameter int unsigned  XLEN     = 32,
  parameter int unsigned  DISP_W   = 12,
  parameter int unsigned  ILEN     = 4,
  parameter logic [31:0]  RESET_PC = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [XLEN-1:0]   fetch_pc,
  input  logic              dec_is_cond,
  input  logic [DISP_W-1:0] dec_disp,
  output logic              dx_valid,
  output logic [XLEN-1:0]   dx_pc,
  output logic              dx_pred_taken,
  output logic [XLEN-1:0]   dx_pred_target,
  input  logic              res_valid,
  input  logic [XLEN-1:0]   res_pc,
  input  logic              res_taken,
  input  logic [XLEN-1:0]   res_target,
  input  logic              res_pred_taken,
  input  logic [XLEN-1:0]   res_pred_target,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_pc,
  output logic              flush
);
  localparam logic [XLEN-1:0] RST_ADDR = XLEN'(RESET_PC);
  localparam logic [XLEN-1:0] STEP     = XLEN'(ILEN);

  // fetch stage state
  logic            fv_q;
  logic [XLEN-1:0] pc_q;
  // decode stage state
  logic            dv_q;
  logic [XLEN-1:0] dpc_q;
  logic            dhit_q;
  logic [XLEN-1:0] dtgt_q;

  logic            btb_hit;
  logic [XLEN-1:0] btb_tgt;
  logic            mis, upd_en;
  logic [XLEN-1:0] fix_pc;
  logic            st_redir;
  logic [XLEN-1:0] st_tgt;
  logic            fire;
  nxt_src_e        src;
  logic [XLEN-1:0] next_pc;

  assign fire = fv_q && fetch_ready;

  nfp_btb #(.XLEN(XLEN)) u_btb (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(pc_q), .lk_hit(btb_hit), .lk_target(btb_tgt),
    .wr_en(upd_en), .wr_pc(res_pc), .wr_target(res_target)
  );

  nfp_static_dir #(.XLEN(XLEN), .DISP_W(DISP_W), .ILEN(ILEN)) u_dir (
    .d_valid(dv_q), .d_pc(dpc_q), .d_is_cond(dec_is_cond), .d_disp(dec_disp),
    .d_btb_hit(dhit_q), .d_btb_target(dtgt_q),
    .st_redirect(st_redir), .st_target(st_tgt),
    .pred_taken(dx_pred_taken), .pred_target(dx_pred_target)
  );

  nfp_resolve #(.XLEN(XLEN), .ILEN(ILEN)) u_res (
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .res_pred_taken(res_pred_taken),
    .res_pred_target(res_pred_target),
    .mispredict(mis), .fix_pc(fix_pc), .upd_en(upd_en)
  );

  always_comb begin
    src = SRC_SEQ;
    if (mis)                  src = SRC_RES;
    else if (st_redir)        src = SRC_DEC;
    else if (fire && btb_hit) src = SRC_BTB;
    unique case (src)
      SRC_RES: next_pc = fix_pc;
      SRC_DEC: next_pc = st_tgt;
      SRC_BTB: next_pc = btb_tgt;
      default: next_pc = pc_q + STEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fv_q   <= 1'b0;
      pc_q   <= RST_ADDR;
      dv_q   <= 1'b0;
      dpc_q  <= '0;
      dhit_q <= 1'b0;
      dtgt_q <= '0;
    end else begin
      fv_q <= 1'b1;
      if (src == SRC_RES || src == SRC_DEC || fire) pc_q <= next_pc;
      dv_q <= fire && !mis && !st_redir;
      if (fire && !mis && !st_redir) begin
        dpc_q  <= pc_q;
        dhit_q <= btb_hit;
        dtgt_q <= btb_tgt;
      end
    end
  end

  assign fetch_valid = fv_q;
  assign fetch_pc    = pc_q;
  assign dx_valid    = dv_q && !mis;
  assign dx_pc       = dpc_q;
  assign redir_valid = mis || st_redir;
  assign redir_pc    = mis ? fix_pc : st_tgt;
  assign flush       = mis;

  // R1
  reset_pc_chk: assert property (@(posedge clk) $rose(rst_n) |-> fetch_pc == RST_ADDR);
  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !redir_valid) |=> $stable(fetch_pc) && !dx_valid);
  // R5
  redir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> fetch_pc == $past(redir_pc) && !dx_valid);
  // R8
  flush_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> redir_valid && !dx_valid);
endmodule

// File: tb/test_nfp_next_fetch.sv
`timescale 1ns/1ps
module test_nfp_next_fetch;
  localparam int          XLEN = 32;
  localparam int          DW   = 12;
  localparam logic [31:0] RPC  = 32'h100;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic fetch_valid, fetch_ready, dec_is_cond;
  logic [XLEN-1:0] fetch_pc, dx_pc, dx_pred_target, redir_pc;
  logic [DW-1:0] dec_disp;
  logic dx_valid, dx_pred_taken, redir_valid, flush;
  logic res_valid, res_taken, res_pred_taken;
  logic [XLEN-1:0] res_pc, res_target, res_pred_target;

  nfp_next_fetch #(.XLEN(XLEN), .DISP_W(DW), .ILEN(4), .RESET_PC(RPC)) i_nfp_next_fetch (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_pc(fetch_pc), .dec_is_cond(dec_is_cond), .dec_disp(dec_disp),
    .dx_valid(dx_valid), .dx_pc(dx_pc), .dx_pred_taken(dx_pred_taken),
    .dx_pred_target(dx_pred_target), .res_valid(res_valid), .res_pc(res_pc),
    .res_taken(res_taken), .res_target(res_target), .res_pred_taken(res_pred_taken),
    .res_pred_target(res_pred_target), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .flush(flush));

  int tests = 0, fails = 0;

  // behavioural reference state
  bit m_fv, m_dv, m_dhit, m_bv;
  logic [31:0] m_pc, m_dpc, m_dtgt, m_bpc, m_btgt;

  task automatic idle_inputs();
    fetch_ready = 0; dec_is_cond = 0; dec_disp = '0;
    res_valid = 0; res_pc = '0; res_taken = 0; res_target = '0;
    res_pred_taken = 0; res_pred_target = '0;
  endtask

  // Compare every output against the model, then advance the model one clock.
  task automatic step(input string tag);
    logic [31:0] sd, e_dtgt, e_rpc, e_npc;
    bit hit, st, mis, e_dtk, fire;
    string t;
    #1;
    sd    = {{(32-DW){dec_disp[DW-1]}}, dec_disp};
    hit   = m_bv && (m_bpc == m_pc);
    st    = m_dv && dec_is_cond && dec_disp[DW-1] && !m_dhit;
    mis   = res_valid && ((res_taken != res_pred_taken) ||
            (res_taken && res_pred_taken && res_target != res_pred_target));
    fire  = m_fv && fetch_ready;
    e_dtk = m_dhit || (dec_is_cond && dec_disp[DW-1]);
    e_dtgt = m_dhit ? m_dtgt : ((dec_is_cond && dec_disp[DW-1]) ? m_dpc + sd : m_dpc + 4);
    e_rpc = mis ? (res_taken ? res_target : res_pc + 4) : m_dpc + sd;
    t = tag;
    if (t == "") begin
      if (mis) t = "R8"; else if (st) t = "R5"; else if (m_dhit && m_dv) t = "R4";
      else if (m_dv) t = "R6"; else if (!fetch_ready) t = "R3"; else t = "R2";
    end
    tests++;
    if (fetch_valid !== m_fv || fetch_pc !== m_pc || dx_valid !== (m_dv && !mis) ||
        (m_dv && (dx_pc !== m_dpc || dx_pred_taken !== e_dtk || dx_pred_target !== e_dtgt)) ||
        redir_valid !== (mis || st) || flush !== mis ||
        ((mis || st) && redir_pc !== e_rpc)) begin
      fails++;
      $display("FAIL %s: act fv=%0b pc=%h dxv=%0b dxpc=%h tk=%0b tgt=%h rv=%0b rpc=%h fl=%0b | exp fv=%0b pc=%h dxv=%0b dxpc=%h tk=%0b tgt=%h rv=%0b rpc=%h fl=%0b",
        t, fetch_valid, fetch_pc, dx_valid, dx_pc, dx_pred_taken, dx_pred_target,
        redir_valid, redir_pc, flush, m_fv, m_pc, m_dv && !mis, m_dpc, e_dtk, e_dtgt,
        mis || st, e_rpc, mis);
    end
    // model update
    e_npc = m_pc;
    if (mis) e_npc = res_taken ? res_target : res_pc + 4;
    else if (st) e_npc = m_dpc + sd;
    else if (fire) e_npc = hit ? m_btgt : m_pc + 4;
    if (fire && !mis && !st) begin
      m_dpc = m_pc; m_dhit = hit; m_dtgt = m_btgt;
    end
    m_dv = fire && !mis && !st;
    m_pc = e_npc;
    m_fv = 1;
    if (res_valid && res_taken) begin m_bv = 1; m_bpc = res_pc; m_btgt = res_target; end
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #(4ns * 200000);
    fails++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle_inputs();
    m_fv = 0; m_dv = 0; m_dhit = 0; m_bv = 0;
    m_pc = RPC; m_dpc = 0; m_dtgt = 0; m_bpc = 0; m_btgt = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    tests++;
    if (fetch_pc !== RPC || fetch_valid !== 0 || dx_valid !== 0 || redir_valid !== 0) begin
      fails++;
      $display("FAIL R1: act pc=%h fv=%0b dxv=%0b rv=%0b exp pc=%h fv=0 dxv=0 rv=0",
               fetch_pc, fetch_valid, dx_valid, redir_valid, RPC);
    end
    rst_n = 1;
    step("R1");
    fetch_ready = 1; step("R2");
    fetch_ready = 1; step("R2");
    fetch_ready = 0; step("R3");
    fetch_ready = 0; step("R3");
    fetch_ready = 1; step("R2");
    // forward conditional branch: no redirect
    fetch_ready = 1; dec_is_cond = 1; dec_disp = 12'd32; step("R6");
    fetch_ready = 1; dec_is_cond = 1; dec_disp = 12'h7FF; step("R6");
    // backward conditional branch: redirect and squash
    fetch_ready = 1; dec_is_cond = 1; dec_disp = -12'sd12; step("R5");
    fetch_ready = 1; step("R5");
    fetch_ready = 1; dec_is_cond = 1; dec_disp = 12'h800; step("R5");
    fetch_ready = 1; step("R2");
    // wrong direction: taken branch at 0x200 -> 0x180, writes the entry
    fetch_ready = 1; res_valid = 1; res_pc = 32'h200; res_taken = 1;
    res_target = 32'h180; res_pred_taken = 0; step("R8");
    // steer fetch to 0x200 via not-taken misprediction at 0x1FC
    fetch_ready = 1; res_valid = 1; res_pc = 32'h1FC; res_taken = 0;
    res_pred_taken = 1; res_pred_target = 32'h40; step("R8");
    fetch_ready = 1; step("R7");
    fetch_ready = 1; dec_is_cond = 1; dec_disp = -12'sd4; step("R4");
    fetch_ready = 1; step("R2");
    // matching prediction: no flush, entry overwritten
    fetch_ready = 1; res_valid = 1; res_pc = 32'h188; res_taken = 1;
    res_target = 32'h300; res_pred_taken = 1; res_pred_target = 32'h300; step("R10");
    // target mismatch while both taken
    fetch_ready = 1; res_valid = 1; res_pc = 32'h184; res_taken = 1;
    res_target = 32'h188; res_pred_taken = 1; res_pred_target = 32'h500; step("R8");
    fetch_ready = 1; step("R7");
    fetch_ready = 1; step("R4");
    // misprediction and decode redirect in the same cycle
    fetch_ready = 1; step("R2");
    fetch_ready = 1; dec_is_cond = 1; dec_disp = -12'sd64; res_valid = 1;
    res_pc = 32'h400; res_taken = 0; res_pred_taken = 1; res_pred_target = 32'h10;
    step("R9");
    fetch_ready = 1; step("R9");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      fetch_ready = ($urandom % 4) != 0;
      dec_is_cond = ($urandom % 3) == 0;
      case ($urandom % 4)
        0: dec_disp = 12'h800;
        1: dec_disp = 12'h7FF;
        default: dec_disp = DW'($urandom);
      endcase
      if (($urandom % 5) == 0) begin
        res_valid = 1;
        res_pc = m_pc - 32'(($urandom % 8) * 4);
        res_taken = $urandom % 2;
        res_target = 32'h100 + 32'(($urandom % 64) * 4);
        res_pred_taken = ($urandom % 3 == 0) ? !res_taken : res_taken;
        res_pred_target = ($urandom % 4 == 0) ? res_target + 4 : res_target;
      end
      step("");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule